// File: doc/BRIEF.md
# Debounced Multi-Line Interrupt Detector

This block watches a set of external input lines, up to eight. It raises one shared interrupt when a line has held its active level for a programmed number of millisecond ticks. Each line has its own enable, polarity and debounce period. The period is counted on a 1 ms tick enable that a prescaler outside the block supplies.

A line that qualifies sets its status bit once. It then locks and stays quiet until software rearms it. A glitch back to the inactive level during counting starts the count again. A registered enable reports whether any counter is busy, so the counter clock can be gated off while all lines are idle.

Software reaches the block through a simple synchronous register port. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `debounce_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and `cnt_gate_en` is 0.
- R2: An enabled, unlocked line whose active level is held without a break fires on the (D+1)-th counted tick, where D is the effective period. Firing sets its status bit (address 3, bit = line index). After only D ticks, nothing is set.
- R3: If the line returns to its inactive level before it fires, the count restarts. A fresh D+1 ticks are then needed.
- R4: A pulse that sees no more than one tick is ignored and never sets status.
- R5: The period register for line i is 12 bits at address 8+i and reads back as written. The value 0 acts as 1. Values above 4000 act as 4000.
- R6: Polarity register at address 2'd1 selects the active level: bit = 1 means active high, bit = 0 means active low.
- R7: After it fires, a line is locked and produces no further events. The lock state reads at address 4. Writing 1 to a bit at address 4 rearms that line. A rearmed line that is still active counts afresh from zero.
- R8: Status bits are write-1-to-clear at address 3. Bits written as 0 are left unchanged.
- R9: `irq` is high exactly when some line has both its status bit and its mask bit set. The mask is at address 2.
- R10: `cnt_gate_en` goes high one clock after some line becomes busy, and low one clock after no line is busy. A line is busy when it is enabled, unlocked and at its active level. Counters advance only on a tick while `cnt_gate_en` is high.
- R11: The enable register is at address 0. A disabled line does not count and its count is cleared.
- R12: Each raw input passes through two synchronizing flops before it reaches the counting logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| raw_in | input | NCH | Asynchronous external lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| irq | output | 1 | Shared interrupt |
| cnt_gate_en | output | 1 | Registered clock-enable for the counters |

## Verification
The bench targets the tick count at which a line fires. A design with an off-by-one count would fire after D ticks, and so would accept a sub-millisecond pulse. The bench also glitches a line in mid-count: a design that paused instead of restarting would fire early. It writes 0 and an over-range value into a period register, to catch a missing clamp that would fire on the first tick or wrap. It then holds a line active across a status clear and a rearm, which exposes a lock that leaks repeat events or never re-counts. Finally, it times the gate enable against the two-flop synchronizer, which shows up a missing or extra pipeline stage.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    RA_ENABLE   = 4'd0,
    RA_POLARITY = 4'd1,
    RA_MASK     = 4'd2,
    RA_STATUS   = 4'd3,
    RA_LOCK     = 4'd4,
    RA_PERIOD0  = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/dbi_sync.sv
module dbi_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/dbi_channel.sv
module dbi_channel #(
  parameter int CNT_W  = 12,
  parameter int MAX_DB = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl,
  input  logic             en,
  input  logic             pol,
  input  logic [CNT_W-1:0] period,
  input  logic             tick,
  input  logic             gate_en,
  input  logic             rearm,
  output logic             busy,
  output logic             fire,
  output logic             locked
);
  // Effective debounce length: zero acts as one, large values are clamped.
  function automatic logic [CNT_W-1:0] eff_period(input logic [CNT_W-1:0] raw);
    if (raw == '0) return CNT_W'(1);
    if (raw > CNT_W'(MAX_DB)) return CNT_W'(MAX_DB);
    return raw;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             lock_q;
  logic             active;
  logic             step;

  assign active = pol ? lvl : ~lvl;
  assign busy   = en & ~lock_q & active;
  assign step   = busy & tick & gate_en;
  assign fire   = step & (cnt_q >= eff_period(period));
  assign locked = lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      if (!busy || fire) cnt_q <= '0;
      else if (step)     cnt_q <= cnt_q + CNT_W'(1);
      if (fire)          lock_q <= 1'b1;
      else if (rearm)    lock_q <= 1'b0;
    end
  end

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !rearm) |=> lock_q);

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_DB));

  // R10
  advance_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q) && cnt_q != '0) |-> $past(gate_en && tick));

  // R2
  lock_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(tick));
endmodule

// File: rtl/dbi_regs.sv
module dbi_regs
  import dbi_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int CNT_W = 12,
  parameter int DW    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [REG_AW-1:0]  addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  input  logic [NCH-1:0]     fire_vec,
  input  logic [NCH-1:0]     lock_vec,
  output logic [NCH-1:0]     en_q,
  output logic [NCH-1:0]     pol_q,
  output logic [NCH-1:0]     mask_q,
  output logic [NCH-1:0]     status_q,
  output logic [NCH*CNT_W-1:0] period_flat,
  output logic [NCH-1:0]     rearm_vec
);
  logic [CNT_W-1:0] period_q [NCH];
  logic [NCH-1:0]   clr_vec;
  logic [DW-1:0]    period_rd;
  logic             unused_wdata_bits;

  assign unused_wdata_bits = ^wdata;
  assign clr_vec   = (wr && addr == RA_STATUS) ? wdata[NCH-1:0] : '0;
  assign rearm_vec = (wr && addr == RA_LOCK)   ? wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      pol_q    <= '0;
      mask_q   <= '0;
      status_q <= '0;
    end else begin
      if (wr && addr == RA_ENABLE)   en_q   <= wdata[NCH-1:0];
      if (wr && addr == RA_POLARITY) pol_q  <= wdata[NCH-1:0];
      if (wr && addr == RA_MASK)     mask_q <= wdata[NCH-1:0];
      status_q <= (status_q & ~clr_vec) | fire_vec;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_period
    localparam logic [REG_AW-1:0] MY_ADDR = REG_AW'(RA_PERIOD0) + REG_AW'(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    period_q[i] <= '0;
      else if (wr && addr == MY_ADDR) period_q[i] <= wdata[CNT_W-1:0];
    end
    assign period_flat[i*CNT_W +: CNT_W] = period_q[i];
  end

  always_comb begin
    period_rd = '0;
    for (int i = 0; i < NCH; i++)
      if (addr == REG_AW'(RA_PERIOD0) + REG_AW'(i)) period_rd = DW'(period_q[i]);
  end

  always_comb begin
    case (addr)
      RA_ENABLE:   rdata = DW'(en_q);
      RA_POLARITY: rdata = DW'(pol_q);
      RA_MASK:     rdata = DW'(mask_q);
      RA_STATUS:   rdata = DW'(status_q);
      RA_LOCK:     rdata = DW'(lock_vec);
      default:     rdata = period_rd;
    endcase
  end

  // R8
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == RA_STATUS) |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/debounce_irq_ctrl.sv
module debounce_irq_ctrl
  import dbi_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int CNT_W  = 12,
  parameter int MAX_DB = 4000,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1ms,
  input  logic [NCH-1:0]    raw_in,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq,
  output logic              cnt_gate_en
);
  logic [NCH-1:0]       lvl_vec;
  logic [NCH-1:0]       busy_vec;
  logic [NCH-1:0]       fire_vec;
  logic [NCH-1:0]       lock_vec;
  logic [NCH-1:0]       en_q, pol_q, mask_q, status_q, rearm_vec;
  logic [NCH*CNT_W-1:0] period_flat;
  logic                 gate_q;

  dbi_sync #(.W(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(lvl_vec)
  );

  dbi_regs #(.NCH(NCH), .CNT_W(CNT_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .fire_vec(fire_vec),
    .lock_vec(lock_vec), .en_q(en_q), .pol_q(pol_q), .mask_q(mask_q),
    .status_q(status_q), .period_flat(period_flat), .rearm_vec(rearm_vec)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dbi_channel #(.CNT_W(CNT_W), .MAX_DB(MAX_DB)) u_ch (
      .clk(clk), .rst_n(rst_n), .lvl(lvl_vec[i]), .en(en_q[i]),
      .pol(pol_q[i]), .period(period_flat[i*CNT_W +: CNT_W]),
      .tick(tick_1ms), .gate_en(gate_q), .rearm(rearm_vec[i]),
      .busy(busy_vec[i]), .fire(fire_vec[i]), .locked(lock_vec[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= |busy_vec;
  end

  assign cnt_gate_en = gate_q;
  assign irq         = |(status_q & mask_q);

  // R9
  fire_to_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(fire_vec & mask_q) && !reg_wr) |=> irq);
endmodule

// File: tb/debounce_irq_ctrl_tb.sv
module debounce_irq_ctrl_tb;
  localparam int NCH = 8;
  localparam int DW  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_1ms = 1'b0;
  logic [NCH-1:0] raw_in = '0;
  logic          reg_wr = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq;
  logic          cnt_gate_en;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  debounce_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .raw_in(raw_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .cnt_gate_en(cnt_gate_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic tick_n(input int n);
    for (int k = 0; k < n; k++) begin
      repeat (3) @(negedge clk);
      tick_1ms = 1'b1;
      @(negedge clk);
      tick_1ms = 1'b0;
    end
  endtask

  task automatic set_raw(input logic [NCH-1:0] v);
    @(negedge clk);
    raw_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic clean();
    wr_reg(4'd0, '0);
    wr_reg(4'd1, '0);
    wr_reg(4'd2, '0);
    set_raw('0);
    wr_reg(4'd3, 16'hFFFF);
    wr_reg(4'd4, 16'hFFFF);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    for (int a = 0; a < 16; a++) begin
      if (a < 5 || a >= 8) begin
        rd_reg(4'(a), d);
        chk("R1 register reset", 32'(d), 0);
      end
    end
    chk("R1 irq reset", 32'(irq), 0);
    chk("R1 gate reset", 32'(cnt_gate_en), 0);
  endtask

  task automatic t_basic_and_lock();
    logic [DW-1:0] d;
    wr_reg(4'd8, 16'd3);
    wr_reg(4'd1, 16'h01);
    wr_reg(4'd2, 16'h01);
    wr_reg(4'd0, 16'h01);
    // R12 / R10: two sync stages then one gate register
    @(negedge clk); raw_in = 8'h01;
    @(negedge clk); chk("R12 gate after one edge", 32'(cnt_gate_en), 0);
    @(negedge clk); chk("R12 gate after two edges", 32'(cnt_gate_en), 0);
    @(negedge clk); chk("R10 gate after three edges", 32'(cnt_gate_en), 1);
    tick_n(3);
    rd_reg(4'd3, d);
    chk("R2 no event after D ticks", 32'(d), 0);
    chk("R9 irq low before event", 32'(irq), 0);
    tick_n(1);
    rd_reg(4'd3, d);
    chk("R2 event on D+1 tick", 32'(d), 32'h01);
    chk("R9 irq high", 32'(irq), 1);
    rd_reg(4'd4, d);
    chk("R7 locked after event", 32'(d), 32'h01);
    repeat (2) @(negedge clk);
    chk("R10 gate low when idle", 32'(cnt_gate_en), 0);
    wr_reg(4'd3, 16'h01);
    chk("R8 irq after clear", 32'(irq), 0);
    tick_n(10);
    rd_reg(4'd3, d);
    chk("R7 no repeat while locked", 32'(d), 0);
    wr_reg(4'd4, 16'h01);
    rd_reg(4'd4, d);
    chk("R7 unlocked by rearm", 32'(d), 0);
    tick_n(3);
    rd_reg(4'd3, d);
    chk("R7 fresh count after rearm", 32'(d), 0);
    tick_n(1);
    rd_reg(4'd3, d);
    chk("R7 fires again after rearm", 32'(d), 32'h01);
    clean();
  endtask

  task automatic t_restart();
    logic [DW-1:0] d;
    wr_reg(4'd9, 16'd3);
    wr_reg(4'd1, 16'h02);
    wr_reg(4'd0, 16'h02);
    set_raw(8'h02);
    tick_n(3);
    set_raw(8'h00);
    set_raw(8'h02);
    tick_n(3);
    rd_reg(4'd3, d);
    chk("R3 glitch restarts count", 32'(d), 0);
    tick_n(1);
    rd_reg(4'd3, d);
    chk("R3 event after full recount", 32'(d), 32'h02);
    clean();
  endtask

  task automatic t_short_pulse();
    logic [DW-1:0] d;
    wr_reg(4'd9, 16'd1);
    wr_reg(4'd1, 16'h02);
    wr_reg(4'd0, 16'h02);
    set_raw(8'h02);
    tick_n(1);
    set_raw(8'h00);
    tick_n(4);
    rd_reg(4'd3, d);
    chk("R4 one-tick pulse ignored", 32'(d), 0);
    clean();
  endtask

  task automatic t_polarity_low();
    logic [DW-1:0] d;
    wr_reg(4'd10, 16'd2);
    wr_reg(4'd1, 16'h00);
    wr_reg(4'd0, 16'h04);
    set_raw(8'h04);
    tick_n(5);
    rd_reg(4'd3, d);
    chk("R6 high level ignored when active low", 32'(d), 0);
    set_raw(8'h00);
    tick_n(2);
    rd_reg(4'd3, d);
    chk("R6 active low before D+1", 32'(d), 0);
    tick_n(1);
    rd_reg(4'd3, d);
    chk("R6 active low event", 32'(d), 32'h04);
    clean();
  endtask

  task automatic t_period_limits();
    logic [DW-1:0] d;
    wr_reg(4'd11, 16'd0);
    wr_reg(4'd1, 16'h08);
    wr_reg(4'd0, 16'h08);
    set_raw(8'h08);
    tick_n(1);
    rd_reg(4'd3, d);
    chk("R5 zero period acts as one (1 tick)", 32'(d), 0);
    tick_n(1);
    rd_reg(4'd3, d);
    chk("R5 zero period acts as one (2 ticks)", 32'(d), 32'h08);
    clean();
    wr_reg(4'd12, 16'h0FFF);
    rd_reg(4'd12, d);
    chk("R5 period readback", 32'(d), 32'h0FFF);
    wr_reg(4'd1, 16'h10);
    wr_reg(4'd0, 16'h10);
    set_raw(8'h10);
    tick_n(4000);
    rd_reg(4'd3, d);
    chk("R5 clamp no event at 4000", 32'(d), 0);
    tick_n(1);
    rd_reg(4'd3, d);
    chk("R5 clamp event at 4001", 32'(d), 32'h10);
    clean();
  endtask

  task automatic t_mask_w1c_shared();
    logic [DW-1:0] d;
    wr_reg(4'd13, 16'd1);
    wr_reg(4'd14, 16'd1);
    wr_reg(4'd1, 16'h60);
    wr_reg(4'd2, 16'h20);
    wr_reg(4'd0, 16'h60);
    set_raw(8'h60);
    tick_n(2);
    rd_reg(4'd3, d);
    chk("R9 both status set", 32'(d), 32'h60);
    chk("R9 irq from masked line", 32'(irq), 1);
    wr_reg(4'd3, 16'h20);
    rd_reg(4'd3, d);
    chk("R8 partial clear keeps other bit", 32'(d), 32'h40);
    chk("R9 unmasked status gives no irq", 32'(irq), 0);
    wr_reg(4'd2, 16'h40);
    chk("R9 irq after unmasking", 32'(irq), 1);
    wr_reg(4'd3, 16'h40);
    chk("R8 irq after full clear", 32'(irq), 0);
    clean();
  endtask

  task automatic t_disable();
    logic [DW-1:0] d;
    wr_reg(4'd15, 16'd3);
    wr_reg(4'd1, 16'h80);
    set_raw(8'h80);
    tick_n(5);
    rd_reg(4'd3, d);
    chk("R11 disabled line no event", 32'(d), 0);
    chk("R11 disabled line gate low", 32'(cnt_gate_en), 0);
    wr_reg(4'd0, 16'h80);
    tick_n(2);
    wr_reg(4'd0, 16'h00);
    wr_reg(4'd0, 16'h80);
    tick_n(3);
    rd_reg(4'd3, d);
    chk("R11 disable clears count", 32'(d), 0);
    tick_n(1);
    rd_reg(4'd3, d);
    chk("R11 event after re-enable", 32'(d), 32'h80);
    clean();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic_and_lock();
    t_restart();
    t_short_pulse();
    t_polarity_low();
    t_period_limits();
    t_mask_w1c_shared();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule